// File: doc/BRIEF.md
# Adaptive Boost Frequency Computer

This block sits next to a memory activity monitor channel. It reacts when the monitor reports that the averaged activity has stayed above or below its watermarks for several sampling periods in a row. Each report adjusts a boost value. An upper breach grows the boost geometrically and adds a fixed step. A lower breach shrinks it geometrically until it snaps to zero. The block then decides which of the monitor's two consecutive-breach enables are re-armed, so a boost that is pinned at a limit stops raising further events. On each event it also recomputes the average-band watermarks and the period watermarks, and it derives a target memory frequency. That target is taken from the averaged count plus the boost. When the channel's dependency threshold is met, the target is lifted to a floor that depends on the CPU clock.

All frequencies are in kHz and all arithmetic is unsigned and 32 bits wide, truncating on overflow. Every divide goes through one shared sequential divider, so each event takes a few hundred cycles. Events that arrive during a computation wait in a small queue and are handled in arrival order. The configuration inputs must stay stable from an event until its done pulse.

Top module: `boost_governor`

## Requirements
- R1: After reset, boost_o is 0, arm_above_o and arm_below_o are 1, done_o and busy_o are 0, and every watermark and target output is 0.
- R2: An upper breach sets boost to (boost*up_coef)/100 + 16000. If that value is below fmax_i, arm_above_o is set to 1. arm_below_o is set to 1.
- R3: If the upper-breach result is at or above fmax_i, boost becomes exactly fmax_i and arm_above_o is 0.
- R4: A lower breach sets boost to (boost*dn_coef)/100 and sets arm_above_o to 1. arm_below_o is 1 while the result is 8000 or more.
- R5: A lower-breach result below 8000 becomes 0, and arm_below_o is then 0.
- R6: An upper and a lower breach in the same cycle count as one upper breach and give exactly one done pulse.
- R7: With dep_thr_i nonzero, an average at or above dep_thr_i forces arm_below_o to 1. An average below it together with a zero boost forces arm_below_o to 0.
- R8: With band = ((fmax*6)/1000)*12, avg_wm_hi_o = avg + band and avg_wm_lo_o = max(avg, band) - band.
- R9: per_wm_hi_o = (fcur*12*up_thr)/100 and per_wm_lo_o = (fcur*12*dn_thr)/100.
- R10: target_o = ((avg/12)*(10000/up_thr))/100 + new boost.
- R11: With dep_thr_i nonzero and the average at or above it, target_o is raised to at least a floor, and the floor is clamped to fmax_i. The floor is the first matching CPU row, searched from the highest row down. CPU at or above 1400000 gives fmax. At or above 1200000 gives 750000; 1100000 gives 600000; 1000000 gives 500000; 800000 gives 375000; 500000 gives 200000; 250000 gives 100000. Any lower CPU frequency gives 0.
- R12: Each accepted event yields exactly one done_o pulse, one cycle wide, and all outputs update in that cycle. Events that arrive while busy are queued and processed in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| brk_up_i | input | 1 | Consecutive upper-breach pulse |
| brk_dn_i | input | 1 | Consecutive lower-breach pulse |
| avg_cnt_i | input | 32 | Sampled average activity count |
| fmax_i | input | 32 | Maximum memory frequency, kHz |
| fcur_i | input | 32 | Current memory frequency, kHz |
| cpu_khz_i | input | 32 | CPU frequency, kHz |
| dep_thr_i | input | 32 | Dependency threshold; 0 disables it |
| up_coef_i | input | CW | Growth coefficient, percent |
| dn_coef_i | input | CW | Decay coefficient, percent |
| up_thr_i | input | CW | Upper threshold, percent, nonzero |
| dn_thr_i | input | CW | Lower threshold, percent |
| boost_o | output | 32 | Current boost, kHz |
| arm_above_o | output | 1 | Re-arm for consecutive-above detection |
| arm_below_o | output | 1 | Re-arm for consecutive-below detection |
| avg_wm_hi_o | output | 32 | Upper average watermark |
| avg_wm_lo_o | output | 32 | Lower average watermark |
| per_wm_hi_o | output | 32 | Upper period watermark |
| per_wm_lo_o | output | 32 | Lower period watermark |
| target_o | output | 32 | Target frequency, kHz |
| busy_o | output | 1 | Computation running or events queued |
| done_o | output | 1 | One-cycle result strobe |

## Verification
Two situations can land in the same cycle. One is both breach pulses together. The bench raises them in one cycle and expects a single upper-breach result and no second done pulse. The other is a new breach arriving while the divider is still working. The bench sends events back to back, and the scoreboard requires each result to match a model that was advanced in the same order the events were sent.

// File: rtl/bgov_pkg.sv
package bgov_pkg;

  typedef logic [31:0] word_t;

  localparam word_t BOOST_STEP    = 32'd16000;
  localparam word_t BOOST_SNAP    = BOOST_STEP >> 1;
  localparam word_t PERIOD_MS     = 32'd12;
  localparam word_t BAND_PERMILLE = 32'd6;
  localparam word_t PCT_DIV       = 32'd100;
  localparam word_t MILLE_DIV     = 32'd1000;
  localparam word_t SUSTAIN_NUM   = 32'd10000;
  localparam int unsigned LUT_N   = 7;
  localparam word_t FLOOR_IS_MAX  = 32'hFFFF_FFFF;

  typedef enum logic [3:0] {
    ST_IDLE, ST_BOOST, ST_BAND, ST_PHI, ST_PLO,
    ST_AVG, ST_SUST, ST_TGT, ST_DONE
  } step_e;

  typedef struct packed {
    word_t boost;
    logic  above;
    logic  below;
  } boost_t;

  // scaled = boost*coef/100 already divided
  function automatic boost_t f_boost_next(input logic up, input word_t scaled,
                                          input word_t fmax);
    boost_t r;
    if (up) begin
      r.boost = scaled + BOOST_STEP;
      r.below = 1'b1;
      if (r.boost >= fmax) begin
        r.boost = fmax;
        r.above = 1'b0;
      end else begin
        r.above = 1'b1;
      end
    end else begin
      r.boost = scaled;
      r.above = 1'b1;
      if (scaled < BOOST_SNAP) begin
        r.boost = '0;
        r.below = 1'b0;
      end else begin
        r.below = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic logic f_below_dep(input logic below, input word_t avg,
                                       input word_t dep, input word_t boost);
    logic b;
    b = below;
    if (dep != '0) begin
      if (avg >= dep) b = 1'b1;
      else if (boost == '0) b = 1'b0;
    end
    return b;
  endfunction

  function automatic word_t f_wm_lo(input word_t avg, input word_t band);
    return ((avg >= band) ? avg : band) - band;
  endfunction

  function automatic word_t f_apply_floor(input word_t raw, input word_t flr,
                                          input logic hit);
    return (hit && (flr > raw)) ? flr : raw;
  endfunction

  function automatic word_t f_cpu_knee(input int unsigned idx);
    case (idx)
      0:       return 32'd1400000;
      1:       return 32'd1200000;
      2:       return 32'd1100000;
      3:       return 32'd1000000;
      4:       return 32'd800000;
      5:       return 32'd500000;
      default: return 32'd250000;
    endcase
  endfunction

  function automatic word_t f_mem_floor(input int unsigned idx);
    case (idx)
      0:       return FLOOR_IS_MAX;
      1:       return 32'd750000;
      2:       return 32'd600000;
      3:       return 32'd500000;
      4:       return 32'd375000;
      5:       return 32'd200000;
      default: return 32'd100000;
    endcase
  endfunction

endpackage

// File: rtl/bgov_divider.sv
module bgov_divider #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quo
);
  localparam int unsigned CNTW = $clog2(W + 1);

  logic [W-1:0]    rem_q;
  logic [CNTW-1:0] cnt_q;
  logic [W:0]      rem_sh;
  logic [W:0]      diff;

  assign rem_sh = {rem_q, quo[W-1]};
  assign diff   = rem_sh - {1'b0, den};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
      cnt_q <= '0;
      quo   <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        quo   <= num;
        rem_q <= '0;
        cnt_q <= CNTW'(W);
        busy  <= 1'b1;
      end else if (busy) begin
        if (!diff[W]) begin
          rem_q <= diff[W-1:0];
          quo   <= {quo[W-2:0], 1'b1};
        end else begin
          rem_q <= rem_sh[W-1:0];
          quo   <= {quo[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNTW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  AST_DIV_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12
  AST_DIV_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy); // R12

endmodule

// File: rtl/bgov_evq.sv
module bgov_evq #(
  parameter int unsigned DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic push_up,
  input  logic pop,
  output logic empty,
  output logic head_up
);
  localparam int unsigned PW   = (DEPTH > 2) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNTW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] kind_mem;
  logic [PW-1:0]    wr_q;
  logic [PW-1:0]    rd_q;
  logic [CNTW-1:0]  cnt_q;
  logic             full;
  logic             do_push;
  logic             do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNTW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head_up = kind_mem[rd_q];

  function automatic logic [PW-1:0] f_wrap(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_mem <= '0;
      wr_q     <= '0;
      rd_q     <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) begin
        kind_mem[wr_q] <= push_up;
        wr_q           <= f_wrap(wr_q);
      end
      if (do_pop) rd_q <= f_wrap(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_Q_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R12

endmodule

// File: rtl/bgov_floor.sv
module bgov_floor
  import bgov_pkg::*;
(
  input  word_t cpu_khz,
  input  word_t fmax,
  output word_t floor_khz
);
  word_t pick;

  always_comb begin
    pick = '0;
    for (int i = LUT_N - 1; i >= 0; i--) begin
      if (cpu_khz >= f_cpu_knee(i)) pick = f_mem_floor(i);
    end
    floor_khz = (pick >= fmax) ? fmax : pick;
  end

endmodule

// File: rtl/boost_governor.sv
module boost_governor
  import bgov_pkg::*;
#(
  parameter int unsigned CW     = 16,
  parameter int unsigned QDEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          brk_up_i,
  input  logic          brk_dn_i,
  input  logic [31:0]   avg_cnt_i,
  input  logic [31:0]   fmax_i,
  input  logic [31:0]   fcur_i,
  input  logic [31:0]   cpu_khz_i,
  input  logic [31:0]   dep_thr_i,
  input  logic [CW-1:0] up_coef_i,
  input  logic [CW-1:0] dn_coef_i,
  input  logic [CW-1:0] up_thr_i,
  input  logic [CW-1:0] dn_thr_i,
  output logic [31:0]   boost_o,
  output logic          arm_above_o,
  output logic          arm_below_o,
  output logic [31:0]   avg_wm_hi_o,
  output logic [31:0]   avg_wm_lo_o,
  output logic [31:0]   per_wm_hi_o,
  output logic [31:0]   per_wm_lo_o,
  output logic [31:0]   target_o,
  output logic          busy_o,
  output logic          done_o
);
  localparam int unsigned DW = $bits(word_t);

  // named internal events
  logic   ev_any;
  logic   q_empty;
  logic   q_head_up;
  logic   q_pop;
  logic   div_start;
  logic   div_busy;
  logic   div_done;
  word_t  div_quo;
  word_t  div_num;
  word_t  div_den;
  logic   is_div_step;
  logic   dep_hit;
  word_t  floor_khz;
  boost_t boost_nx;
  logic   below_nx;

  step_e  step_q;
  logic   issued_q;
  logic   kind_up_q;
  word_t  nb_q;
  logic   ab_q;
  logic   bl_q;
  word_t  band_q;
  word_t  phi_q;
  word_t  plo_q;
  word_t  avg12_q;
  word_t  sust_q;
  word_t  tgt_q;

  assign ev_any  = brk_up_i | brk_dn_i;
  assign q_pop   = (step_q == ST_IDLE) && !q_empty;
  assign dep_hit = (dep_thr_i != '0) && (avg_cnt_i >= dep_thr_i);
  assign busy_o  = (step_q != ST_IDLE) || !q_empty;

  // upper breach wins when both are flagged together
  bgov_evq #(.DEPTH(QDEPTH)) u_evq (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (ev_any),
    .push_up (brk_up_i),
    .pop     (q_pop),
    .empty   (q_empty),
    .head_up (q_head_up)
  );

  bgov_floor u_floor (
    .cpu_khz   (cpu_khz_i),
    .fmax      (fmax_i),
    .floor_khz (floor_khz)
  );

  bgov_divider #(.W(DW)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .num   (div_num),
    .den   (div_den),
    .busy  (div_busy),
    .done  (div_done),
    .quo   (div_quo)
  );

  // operand selection per step
  always_comb begin
    is_div_step = 1'b1;
    div_num     = '0;
    div_den     = 32'd1;
    case (step_q)
      ST_BOOST: begin
        div_num = boost_o * word_t'(kind_up_q ? up_coef_i : dn_coef_i);
        div_den = PCT_DIV;
      end
      ST_BAND: begin
        div_num = fmax_i * BAND_PERMILLE;
        div_den = MILLE_DIV;
      end
      ST_PHI: begin
        div_num = fcur_i * PERIOD_MS * word_t'(up_thr_i);
        div_den = PCT_DIV;
      end
      ST_PLO: begin
        div_num = fcur_i * PERIOD_MS * word_t'(dn_thr_i);
        div_den = PCT_DIV;
      end
      ST_AVG: begin
        div_num = avg_cnt_i;
        div_den = PERIOD_MS;
      end
      ST_SUST: begin
        div_num = SUSTAIN_NUM;
        div_den = word_t'(up_thr_i);
      end
      ST_TGT: begin
        div_num = avg12_q * sust_q;
        div_den = PCT_DIV;
      end
      default: is_div_step = 1'b0;
    endcase
  end

  assign div_start = is_div_step && !issued_q;
  assign boost_nx  = f_boost_next(kind_up_q, div_quo, fmax_i);
  assign below_nx  = f_below_dep(boost_nx.below, avg_cnt_i, dep_thr_i, boost_nx.boost);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q      <= ST_IDLE;
      issued_q    <= 1'b0;
      kind_up_q   <= 1'b0;
      nb_q        <= '0;
      ab_q        <= 1'b1;
      bl_q        <= 1'b1;
      band_q      <= '0;
      phi_q       <= '0;
      plo_q       <= '0;
      avg12_q     <= '0;
      sust_q      <= '0;
      tgt_q       <= '0;
      boost_o     <= '0;
      arm_above_o <= 1'b1;
      arm_below_o <= 1'b1;
      avg_wm_hi_o <= '0;
      avg_wm_lo_o <= '0;
      per_wm_hi_o <= '0;
      per_wm_lo_o <= '0;
      target_o    <= '0;
      done_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (div_done) issued_q <= 1'b0;
      else if (div_start) issued_q <= 1'b1;

      case (step_q)
        ST_IDLE: begin
          if (q_pop) begin
            kind_up_q <= q_head_up;
            step_q    <= ST_BOOST;
          end
        end
        ST_BOOST: if (div_done) begin
          nb_q   <= boost_nx.boost;
          ab_q   <= boost_nx.above;
          bl_q   <= below_nx;
          step_q <= ST_BAND;
        end
        ST_BAND: if (div_done) begin
          band_q <= div_quo * PERIOD_MS;
          step_q <= ST_PHI;
        end
        ST_PHI: if (div_done) begin
          phi_q  <= div_quo;
          step_q <= ST_PLO;
        end
        ST_PLO: if (div_done) begin
          plo_q  <= div_quo;
          step_q <= ST_AVG;
        end
        ST_AVG: if (div_done) begin
          avg12_q <= div_quo;
          step_q  <= ST_SUST;
        end
        ST_SUST: if (div_done) begin
          sust_q <= div_quo;
          step_q <= ST_TGT;
        end
        ST_TGT: if (div_done) begin
          tgt_q  <= f_apply_floor(div_quo + nb_q, floor_khz, dep_hit);
          step_q <= ST_DONE;
        end
        ST_DONE: begin
          boost_o     <= nb_q;
          arm_above_o <= ab_q;
          arm_below_o <= bl_q;
          avg_wm_hi_o <= avg_cnt_i + band_q;
          avg_wm_lo_o <= f_wm_lo(avg_cnt_i, band_q);
          per_wm_hi_o <= phi_q;
          per_wm_lo_o <= plo_q;
          target_o    <= tgt_q;
          done_o      <= 1'b1;
          step_q      <= ST_IDLE;
        end
        default: step_q <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R12
  AST_UP_ARMS_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && kind_up_q) |-> (arm_below_o || (boost_o == '0))); // R2
  AST_UP_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && kind_up_q) |-> (boost_o <= fmax_i)); // R3
  AST_DN_ARMS_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !kind_up_q) |-> arm_above_o); // R4
  AST_DN_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !kind_up_q && (dep_thr_i == '0)) |-> ((boost_o == '0) == !arm_below_o)); // R5
  AST_DEP_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && dep_hit) |-> arm_below_o); // R7
  AST_AVG_LO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (avg_wm_lo_o <= avg_cnt_i)); // R8
  AST_FLOOR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && dep_hit) |-> (target_o >= floor_khz)); // R11
  AST_START_IDLE_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    div_start |-> !div_busy); // R12

endmodule

// File: tb/boost_governor_test.sv
module boost_governor_test;
  localparam int CLK_NS   = 10;
  localparam int WD_LIMIT = 150000;

  typedef struct {
    logic [31:0] boost;
    bit          ab;
    bit          bl;
    logic [31:0] whi, wlo, phi, plo, tgt;
    string       tag;
    string       ttag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic brk_up = 1'b0, brk_dn = 1'b0;
  logic [31:0] avg = '0, fmax = '0, fcur = '0, cpu = '0, dep = '0;
  logic [15:0] uc = '0, dc = '0, ut = 16'd1, dt = '0;
  logic [31:0] boost_o, whi_o, wlo_o, phi_o, plo_o, tgt_o;
  logic arm_above_o, arm_below_o, busy_o, done_o;

  int checks = 0, fails = 0, done_cnt = 0, push_cnt = 0;
  bit prev_done = 0;
  exp_t sb[$];

  logic [31:0] mb = '0;
  bit mab = 1, mbl = 1;

  always #(CLK_NS/2) clk = ~clk;

  boost_governor uut (
    .clk(clk), .rst_n(rst_n), .brk_up_i(brk_up), .brk_dn_i(brk_dn),
    .avg_cnt_i(avg), .fmax_i(fmax), .fcur_i(fcur), .cpu_khz_i(cpu),
    .dep_thr_i(dep), .up_coef_i(uc), .dn_coef_i(dc), .up_thr_i(ut),
    .dn_thr_i(dt), .boost_o(boost_o), .arm_above_o(arm_above_o),
    .arm_below_o(arm_below_o), .avg_wm_hi_o(whi_o), .avg_wm_lo_o(wlo_o),
    .per_wm_hi_o(phi_o), .per_wm_lo_o(plo_o), .target_o(tgt_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_floor(input logic [31:0] c, input logic [31:0] fm);
    logic [31:0] f;
    if (c >= 32'd1400000) f = fm;
    else if (c >= 32'd1200000) f = 32'd750000;
    else if (c >= 32'd1100000) f = 32'd600000;
    else if (c >= 32'd1000000) f = 32'd500000;
    else if (c >= 32'd800000) f = 32'd375000;
    else if (c >= 32'd500000) f = 32'd200000;
    else if (c >= 32'd250000) f = 32'd100000;
    else f = 32'd0;
    return (f >= fm) ? fm : f;
  endfunction

  // driver: pulse an event and push the expected result
  task automatic fire(input bit up, input bit dn, input string tag, input string ttag);
    exp_t e;
    logic [31:0] prod, nb, band, t, fl, a12, s;
    bit ab, bl;
    prod = mb * (up ? {16'd0, uc} : {16'd0, dc});
    if (up) begin
      nb = prod / 100 + 32'd16000;
      bl = 1;
      if (nb >= fmax) begin nb = fmax; ab = 0; end else ab = 1;
    end else begin
      nb = prod / 100;
      ab = 1;
      if (nb < 32'd8000) begin nb = 0; bl = 0; end else bl = 1;
    end
    if (dep != 0) begin
      if (avg >= dep) bl = 1;
      else if (nb == 0) bl = 0;
    end
    band = fmax * 32'd6;
    band = (band / 1000) * 32'd12;
    e.whi = avg + band;
    e.wlo = ((avg >= band) ? avg : band) - band;
    prod = fcur * 32'd12 * {16'd0, ut};
    e.phi = prod / 100;
    prod = fcur * 32'd12 * {16'd0, dt};
    e.plo = prod / 100;
    a12 = avg / 12;
    s = 32'd10000 / {16'd0, ut};
    prod = a12 * s;
    t = prod / 100 + nb;
    if (dep != 0 && avg >= dep) begin
      fl = ref_floor(cpu, fmax);
      if (fl > t) t = fl;
    end
    e.tgt = t; e.boost = nb; e.ab = ab; e.bl = bl; e.tag = tag; e.ttag = ttag;
    mb = nb; mab = ab; mbl = bl;
    @(negedge clk);
    brk_up = up; brk_dn = dn;
    sb.push_back(e);
    push_cnt++;
    @(negedge clk);
    brk_up = 0; brk_dn = 0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_o && prev_done) chk(0, "R12", "done wider than one cycle", 2, 1);
      if (done_o) begin
        done_cnt++;
        if (sb.size() == 0) chk(0, "R12", "unexpected done", 1, 0);
        else begin
          exp_t e;
          e = sb.pop_front();
          chk(boost_o == e.boost, e.tag, "boost", boost_o, e.boost);
          chk(arm_above_o == e.ab, e.tag, "arm_above", 32'(arm_above_o), 32'(e.ab));
          chk(arm_below_o == e.bl, e.tag, "arm_below", 32'(arm_below_o), 32'(e.bl));
          chk(whi_o == e.whi, "R8", "avg_wm_hi", whi_o, e.whi);
          chk(wlo_o == e.wlo, "R8", "avg_wm_lo", wlo_o, e.wlo);
          chk(phi_o == e.phi, "R9", "per_wm_hi", phi_o, e.phi);
          chk(plo_o == e.plo, "R9", "per_wm_lo", plo_o, e.plo);
          chk(tgt_o == e.tgt, e.ttag, "target", tgt_o, e.tgt);
        end
      end
      prev_done = done_o;
    end
  end

  task automatic run_all();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(boost_o == 0, "R1", "boost", boost_o, 0);
    chk(arm_above_o && arm_below_o, "R1", "arms", {arm_above_o, arm_below_o}, 3);
    chk(!done_o && !busy_o, "R1", "done/busy", {done_o, busy_o}, 0);
    chk(tgt_o == 0 && whi_o == 0, "R1", "target/wm", tgt_o | whi_o, 0);

    // all-traffic style channel
    fmax = 600000; fcur = 300000; uc = 200; dc = 50; ut = 60; dt = 40;
    dep = 0; avg = 20000; cpu = 0;
    fire(1, 0, "R2", "R10"); drain();
    fire(1, 0, "R2", "R10"); drain();
    avg = 100000;
    for (int i = 0; i < 3; i++) begin fire(1, 0, "R2", "R10"); drain(); end
    fire(1, 0, "R3", "R10"); drain();
    fire(1, 0, "R3", "R10"); drain();
    fire(0, 1, "R4", "R10"); drain();
    avg = 10000;
    for (int i = 0; i < 5; i++) begin fire(0, 1, "R4", "R10"); drain(); end
    fire(0, 1, "R5", "R10"); drain();
    fire(0, 1, "R5", "R10"); drain();

    // both pulses in one cycle
    fire(1, 1, "R6", "R10"); drain();
    chk(done_cnt == push_cnt, "R6", "done count", done_cnt, push_cnt);

    // back-to-back events, queued while busy
    fire(1, 0, "R12", "R10");
    fire(0, 1, "R12", "R10");
    fire(1, 0, "R12", "R10");
    drain();
    chk(done_cnt == push_cnt, "R12", "done count", done_cnt, push_cnt);

    // CPU style channel with dependency threshold
    uc = 800; dc = 90; ut = 27; dt = 10; dep = 50000; avg = 40000;
    fire(1, 0, "R2", "R10"); drain();
    for (int i = 0; i < 45; i++) begin fire(0, 1, "R7", "R10"); drain(); end
    chk(arm_below_o == 0, "R7", "below cleared at zero boost", 32'(arm_below_o), 0);
    avg = 60000; cpu = 1000000;
    fire(0, 1, "R7", "R11"); drain();
    chk(arm_below_o == 1, "R7", "below forced by average", 32'(arm_below_o), 1);
    cpu = 1500000;
    fire(0, 1, "R11", "R11"); drain();
    chk(tgt_o == fmax, "R11", "floor clamped to max", tgt_o, fmax);
    cpu = 100000;
    fire(1, 0, "R11", "R11"); drain();
    cpu = 800000;
    fire(0, 1, "R11", "R11"); drain();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (WD_LIMIT) @(posedge clk);
        fails++;
        $display("FAIL R12 watchdog: actual hung expected all done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule